// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit holds the two 32-bit architectural product registers, HI and LO, and carries out every integer operation that reads or writes them. A core sends one command at a time on a valid/ready command port. Each command carries an operation code and two operands, `rs` and `rt`. Multiplies finish one cycle after acceptance. Divides produce one quotient bit per cycle. Commands that return a value (reading HI, reading LO, and the three-operand low-word multiply) deliver it on a valid/ready result port.

HI and LO are shared between operation families:
- A multiply splits its 64-bit product across the pair.
- A divide puts the remainder in HI and the quotient in LO.
- Multiply-accumulate and multiply-subtract read `{HI,LO}` as one 64-bit value and write the updated value back.

The command port has back-pressure. `cmd_ready` is low while an operation executes and while a result waits to be taken. A read of HI or LO issued behind a long divide therefore waits until the divide has written its result. The result port holds `res_valid` and `res_data` steady until `res_ready` is seen high.

Top module: `muldiv_hilo`

## Requirements
- R1: A command transfers on a rising edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only when no operation is executing and no result is waiting.
- R2: Operation code 0 (signed multiply) and code 1 (unsigned multiply) write bits 63:32 of `rs*rt` to HI and bits 31:0 to LO.
- R3: Code 2 (signed divide) and code 3 (unsigned divide) write the quotient `rs/rt` to LO and the remainder to HI. Signed division rounds toward zero, and the remainder takes the sign of the dividend. `busy` stays high for 32 cycles.
- R4: Code 4 (signed) and code 5 (unsigned) multiply-add write `{HI,LO} + rs*rt` back into HI:LO. Carries propagate from LO into HI.
- R5: Code 6 (signed) and code 7 (unsigned) multiply-subtract write `{HI,LO} - rs*rt` back into HI:LO. Borrows propagate from LO into HI.
- R6: Code 8 returns the low 32 bits of the signed product on the result port and leaves HI and LO unchanged.
- R7: Code 10 writes `rs` to HI and code 12 writes `rs` to LO, with `cmd_ready` high again on the next cycle. Code 9 returns HI and code 11 returns LO on the result port.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` stays high, `res_data` stays stable and no command is accepted.
- R9: After reset, HI and LO are zero, `busy` and `res_valid` are low, and `cmd_ready` is high.
- R10: A divide by zero completes in the same 32 cycles as any other divide, and the unit then accepts commands again. The values left in HI and LO are unspecified.
- R11: Codes 13 to 15 are accepted and change nothing: HI and LO keep their values, no result is produced, and `cmd_ready` is high again on the next cycle.
- R12: `busy` is high for exactly one cycle after a multiply-family command (codes 0, 1 and 4 to 8) is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The unit can take a command |
| cmd_op | input | 4 | Operation code |
| cmd_rs | input | 32 | First operand |
| cmd_rt | input | 32 | Second operand |
| res_valid | output | 1 | A result is waiting |
| res_ready | input | 1 | The consumer takes the result |
| res_data | output | 32 | Result word |
| busy | output | 1 | A multiply or divide is executing |

## Verification
The assertions assume that `cmd_op` is a known value whenever `cmd_valid` is high. They also assume the consumer follows the result handshake, so a result is only taken while `res_valid` is high. The stimulus changes inputs only on falling edges. It holds `cmd_valid` until a transfer happens and drops it right after. It raises `res_ready` only after `res_valid` has been seen, and keeps `res_ready` low for several cycles in the hold case. Every value read back from HI or LO is compared against a 64-bit model. The one exception is the state right after a divide by zero, which is overwritten before it is read.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [3:0] {
    OP_MULT  = 4'd0,
    OP_MULTU = 4'd1,
    OP_DIV   = 4'd2,
    OP_DIVU  = 4'd3,
    OP_MADD  = 4'd4,
    OP_MADDU = 4'd5,
    OP_MSUB  = 4'd6,
    OP_MSUBU = 4'd7,
    OP_MUL3  = 4'd8,
    OP_RDHI  = 4'd9,
    OP_WRHI  = 4'd10,
    OP_RDLO  = 4'd11,
    OP_WRLO  = 4'd12
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_RESP
  } mdu_state_e;

  // how the registered product is committed
  typedef enum logic [1:0] {
    MD_SET,
    MD_ADD,
    MD_SUB,
    MD_RET
  } mul_dst_e;

endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           en,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] ext_a;
  logic [PW-1:0] ext_b;

  // sign- or zero-extend to full width; the truncated product is exact
  assign ext_a = {{W{sgn & a[W-1]}}, a};
  assign ext_b = {{W{sgn & b[W-1]}}, b};

  always_ff @(posedge clk) begin
    if (en) prod <= ext_a * ext_b;
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W) + 1;

  logic          run;
  logic [CW-1:0] cnt;
  logic [W-1:0]  q_r;
  logic [W-1:0]  r_r;
  logic [W-1:0]  dvs;
  logic          neg_q;
  logic          neg_r;

  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;
  logic [W:0]    r_sh;
  logic [W:0]    diff;
  logic [W-1:0]  q_nxt;
  logic [W-1:0]  r_nxt;

  assign mag_a = (sgn && a[W-1]) ? (~a + 1'b1) : a;
  assign mag_b = (sgn && b[W-1]) ? (~b + 1'b1) : b;

  // one restoring step: shift in the next dividend bit, try a subtract
  assign r_sh  = {r_r, q_r[W-1]};
  assign diff  = r_sh - {1'b0, dvs};
  assign q_nxt = {q_r[W-2:0], ~diff[W]};
  assign r_nxt = diff[W] ? r_sh[W-1:0] : diff[W-1:0];

  assign done = run && (cnt == CW'(W - 1));
  assign quo  = neg_q ? (~q_nxt + 1'b1) : q_nxt;
  assign rem  = neg_r ? (~r_nxt + 1'b1) : r_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      q_r   <= '0;
      r_r   <= '0;
      dvs   <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
    end else if (start) begin
      run   <= 1'b1;
      cnt   <= '0;
      q_r   <= mag_a;
      r_r   <= '0;
      dvs   <= mag_b;
      neg_q <= sgn & (a[W-1] ^ b[W-1]);
      neg_r <= sgn & a[W-1];
    end else if (run) begin
      q_r <= q_nxt;
      r_r <= r_nxt;
      cnt <= cnt + 1'b1;
      if (done) run <= 1'b0;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_rs,
  input  logic [W-1:0] cmd_rt,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data,
  output logic         busy
);
  localparam int PW = 2 * W;

  mdu_state_e    state;
  mul_dst_e      dst;
  logic [W-1:0]  hi;
  logic [W-1:0]  lo;
  logic [W-1:0]  res_q;

  mdu_op_e       op;
  logic          take;
  logic          is_mul;
  logic          is_div;
  logic          mul_sgn;
  mul_dst_e      dst_nxt;
  logic [PW-1:0] prod;
  logic [PW-1:0] pair;
  logic          dv_done;
  logic [W-1:0]  dv_quo;
  logic [W-1:0]  dv_rem;

  assign op   = mdu_op_e'(cmd_op);
  assign take = cmd_valid && cmd_ready;
  assign pair = {hi, lo};

  always_comb begin
    is_mul  = 1'b0;
    is_div  = 1'b0;
    mul_sgn = 1'b0;
    dst_nxt = MD_SET;
    unique case (op)
      OP_MULT:  begin is_mul = 1'b1; mul_sgn = 1'b1; end
      OP_MULTU: begin is_mul = 1'b1; end
      OP_MADD:  begin is_mul = 1'b1; mul_sgn = 1'b1; dst_nxt = MD_ADD; end
      OP_MADDU: begin is_mul = 1'b1; dst_nxt = MD_ADD; end
      OP_MSUB:  begin is_mul = 1'b1; mul_sgn = 1'b1; dst_nxt = MD_SUB; end
      OP_MSUBU: begin is_mul = 1'b1; dst_nxt = MD_SUB; end
      OP_MUL3:  begin is_mul = 1'b1; mul_sgn = 1'b1; dst_nxt = MD_RET; end
      OP_DIV:   begin is_div = 1'b1; mul_sgn = 1'b1; end
      OP_DIVU:  begin is_div = 1'b1; end
      default:  begin end
    endcase
  end

  mdu_mult #(.W(W)) mult_i (
    .clk  (clk),
    .en   (take && is_mul),
    .sgn  (mul_sgn),
    .a    (cmd_rs),
    .b    (cmd_rt),
    .prod (prod)
  );

  mdu_div #(.W(W)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (take && is_div),
    .sgn   (mul_sgn),
    .a     (cmd_rs),
    .b     (cmd_rt),
    .done  (dv_done),
    .quo   (dv_quo),
    .rem   (dv_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      dst   <= MD_SET;
      hi    <= '0;
      lo    <= '0;
      res_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            if (is_mul) begin
              state <= ST_MUL;
              dst   <= dst_nxt;
            end else if (is_div) begin
              state <= ST_DIV;
            end else begin
              unique case (op)
                OP_RDHI: begin res_q <= hi; state <= ST_RESP; end
                OP_RDLO: begin res_q <= lo; state <= ST_RESP; end
                OP_WRHI: hi <= cmd_rs;
                OP_WRLO: lo <= cmd_rs;
                default: begin end
              endcase
            end
          end
        end
        ST_MUL: begin
          state <= ST_IDLE;
          unique case (dst)
            MD_SET: {hi, lo} <= prod;
            MD_ADD: {hi, lo} <= pair + prod;
            MD_SUB: {hi, lo} <= pair - prod;
            MD_RET: begin
              res_q <= prod[W-1:0];
              state <= ST_RESP;
            end
            default: begin end
          endcase
        end
        ST_DIV: begin
          if (dv_done) begin
            hi    <= dv_rem;
            lo    <= dv_quo;
            state <= ST_IDLE;
          end
        end
        ST_RESP: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state == ST_MUL) || (state == ST_DIV);
  assign res_valid = (state == ST_RESP);
  assign res_data  = res_q;
endmodule

// File: rtl/mdu_checks.sv
module mdu_checks
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [3:0]   cmd_op,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] res_data,
  input logic         busy
);
  localparam int CW = $clog2(W) + 2;

  logic          take;
  logic          mul_take;
  logic          div_take;
  logic          div_trk;
  logic [CW-1:0] div_cnt;

  assign take     = cmd_valid && cmd_ready;
  assign mul_take = take && (cmd_op inside {4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8});
  assign div_take = take && (cmd_op inside {4'd2, 4'd3});

  // count the busy cycles of a divide
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_trk <= 1'b0;
      div_cnt <= '0;
    end else if (div_take) begin
      div_trk <= 1'b1;
      div_cnt <= '0;
    end else if (div_trk && busy) begin
      div_cnt <= div_cnt + 1'b1;
    end else if (div_trk) begin
      div_trk <= 1'b0;
    end
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!busy && !res_valid)); // R1

  AST_MUL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mul_take |=> busy ##1 !busy); // R12

  AST_DIV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (div_trk && !busy) |-> (div_cnt == CW'(W))); // R3

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R8

  AST_WRITE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cmd_op inside {4'd10, 4'd12})) |=> cmd_ready); // R7

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cmd_op >= 4'd13)) |=> (cmd_ready && !res_valid)); // R11
endmodule

bind muldiv_hilo mdu_checks #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .busy      (busy)
);

// File: tb/muldiv_hilo_tb_top.sv
`timescale 1ns/1ps
module muldiv_hilo_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [3:0]   cmd_op = 4'd0;
  logic [W-1:0] cmd_rs = '0;
  logic [W-1:0] cmd_rt = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [W-1:0] res_data;
  logic         busy;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [W-1:0] hi_m = '0;
  logic [W-1:0] lo_m = '0;

  always #4 clk = ~clk;

  muldiv_hilo #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_rs(cmd_rs), .cmd_rt(cmd_rt), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // present a command and return at the falling edge after it transfers
  task automatic issue(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_rs = a; cmd_rt = b;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic take_result(output logic [W-1:0] d);
    while (!res_valid) @(negedge clk);
    d = res_data;
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic read_pair(input string req);
    logic [W-1:0] d;
    issue(4'd9, '0, '0);
    take_result(d);
    chk({req, " HI"}, 64'(d), 64'(hi_m));
    issue(4'd11, '0, '0);
    take_result(d);
    chk({req, " LO"}, 64'(d), 64'(lo_m));
  endtask

  task automatic load_pair(input logic [W-1:0] h, input logic [W-1:0] l);
    issue(4'd10, h, '0);
    chk("R7 ready after write", 64'(cmd_ready), 64'd1);
    issue(4'd12, l, '0);
    hi_m = h; lo_m = l;
  endtask

  function automatic logic [63:0] ref_prod(input bit sg, input logic [W-1:0] a, input logic [W-1:0] b);
    if (sg) return 64'(longint'($signed(a)) * longint'($signed(b)));
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic t_reset();
    chk("R9 ready", 64'(cmd_ready), 64'd1);
    chk("R9 busy", 64'(busy), 64'd0);
    chk("R9 res_valid", 64'(res_valid), 64'd0);
    read_pair("R9");
  endtask

  task automatic t_move();
    load_pair(32'h1234_5678, 32'h9abc_def0);
    read_pair("R7");
  endtask

  // multiply, accumulate or subtract from a known HI:LO
  task automatic t_mul(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] h0, input logic [W-1:0] l0);
    logic [63:0] p;
    logic [63:0] acc;
    string tag;
    bit sg;
    sg = (op == 4'd0) || (op == 4'd4) || (op == 4'd6);
    load_pair(h0, l0);
    p = ref_prod(sg, a, b);
    acc = {hi_m, lo_m};
    if (op <= 4'd1) begin acc = p; tag = "R2"; end
    else if (op <= 4'd5) begin acc = acc + p; tag = "R4"; end
    else begin acc = acc - p; tag = "R5"; end
    issue(op, a, b);
    chk("R12 busy after multiply", 64'(busy), 64'd1);
    chk("R1 not ready while busy", 64'(cmd_ready), 64'd0);
    @(negedge clk);
    chk("R12 busy one cycle", 64'(busy), 64'd0);
    hi_m = acc[63:32]; lo_m = acc[31:0];
    read_pair(tag);
  endtask

  task automatic t_mul3(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] d;
    logic [63:0] p;
    load_pair(32'hdead_beef, 32'h0bad_f00d);
    p = ref_prod(1'b1, a, b);
    issue(4'd8, a, b);
    take_result(d);
    chk("R6 low product", 64'(d), 64'(p[31:0]));
    read_pair("R6 unchanged");
  endtask

  task automatic t_div(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    int n;
    logic [63:0] q;
    logic [63:0] r;
    if (op == 4'd2) begin
      q = 64'(longint'($signed(a)) / longint'($signed(b)));
      r = 64'(longint'($signed(a)) % longint'($signed(b)));
    end else begin
      q = {32'b0, a} / {32'b0, b};
      r = {32'b0, a} % {32'b0, b};
    end
    issue(op, a, b);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R3 divide cycles", 64'(n), 64'd32);
    hi_m = r[31:0]; lo_m = q[31:0];
    read_pair("R3");
  endtask

  task automatic t_divzero();
    int n;
    issue(4'd2, 32'd77, 32'd0);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R10 divide by zero cycles", 64'(n), 64'd32);
    chk("R10 ready after", 64'(cmd_ready), 64'd1);
    load_pair(32'h0000_0011, 32'h0000_0022);
    read_pair("R10 usable");
  endtask

  task automatic t_hold();
    logic [W-1:0] d;
    load_pair(32'hcafe_0001, 32'h0);
    issue(4'd9, '0, '0);
    cmd_valid = 1'b1; cmd_op = 4'd10; cmd_rs = 32'h5555_5555;
    for (int i = 0; i < 5; i++) begin
      chk("R8 valid held", 64'(res_valid), 64'd1);
      chk("R8 data held", 64'(res_data), 64'(32'hcafe_0001));
      chk("R8 no accept", 64'(cmd_ready), 64'd0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    take_result(d);
    chk("R8 data", 64'(d), 64'(32'hcafe_0001));
    read_pair("R8 no stray write");
  endtask

  task automatic t_undef(input logic [3:0] op);
    load_pair(32'h0f0f_0f0f, 32'hf0f0_f0f0);
    issue(op, 32'hffff_ffff, 32'hffff_ffff);
    chk("R11 ready", 64'(cmd_ready), 64'd1);
    chk("R11 no result", 64'(res_valid), 64'd0);
    read_pair("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_move();
    t_mul(4'd0, 32'd7, 32'hffff_fffd, 32'h1, 32'h2);
    t_mul(4'd1, 32'hffff_ffff, 32'hffff_ffff, 32'h0, 32'h0);
    t_mul(4'd0, 32'hffff_ffff, 32'hffff_ffff, 32'h0, 32'h0);
    t_mul(4'd0, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0);
    t_mul(4'd4, 32'h0001_0000, 32'h0001_0000, 32'h0000_0001, 32'hffff_ffff);
    t_mul(4'd4, 32'hffff_ffff, 32'd5, 32'h0, 32'h0000_0003);
    t_mul(4'd5, 32'hffff_ffff, 32'd2, 32'h7fff_ffff, 32'hffff_ffff);
    t_mul(4'd6, 32'd3, 32'd3, 32'h1, 32'h0000_0004);
    t_mul(4'd6, 32'hffff_fffe, 32'd4, 32'h0, 32'h0);
    t_mul(4'd7, 32'hffff_ffff, 32'hffff_ffff, 32'h0, 32'h0);
    t_mul3(32'hffff_fffb, 32'd9);
    t_mul3(32'h1234_5678, 32'h0000_1000);
    t_div(4'd2, 32'd100, 32'd7);
    t_div(4'd2, 32'hffff_ff9c, 32'd7);
    t_div(4'd2, 32'd100, 32'hffff_fff9);
    t_div(4'd2, 32'hffff_ff9c, 32'hffff_fff9);
    t_div(4'd3, 32'hffff_ffff, 32'd3);
    t_div(4'd2, 32'h8000_0000, 32'hffff_ffff);
    t_div(4'd3, 32'd5, 32'd9);
    t_divzero();
    t_hold();
    t_undef(4'd13);
    t_undef(4'd15);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule